// File: doc/BRIEF.md
# Interrupt Status Mask Intrusion Controller

This block collects limit-violation and event flags for a hardware-monitor chip and turns them into one active-low interrupt line. The flags are held in two byte-wide status registers. A status bit is set when its event shows up and stays set until software reads that register. Two byte-wide mask registers decide which of the held flags may pull the interrupt low.

The second status register does more than take raw flags. It catches a chassis-intrusion input that is high, a thermal input that is pulled low, and two remote-diode fault flags. Its two reserved positions always read zero.

A command register clears the external intrusion latch. Writing a one to its top bit drives the intrusion-pulse output low for a fixed, parameterised number of clock cycles. The default count is 20 ms at a 250 MHz clock. The bit reads back as one while the pulse runs and clears itself when the pulse ends.

The block also has a scratch byte that is kept for compatibility. Software reaches all registers through a plain byte-wide read/write port with an 8-bit address.

Top module: `imc_top`

## Requirements
- R1: After reset every register reads 0x00, `irq_no` is high and `intr_pulse_no` is high.
- R2: The register map is: status one at 0x41, status two at 0x42, mask one at 0x43, mask two at 0x44, scratch at 0x45 and intrusion-clear at 0x46. Any other address reads 0x00, and a write to it changes no register.
- R3: Status bits are sticky. A bit is set on the clock edge where its event is high. It is cleared only by the edge where that same register is read (`reg_re_i` high with its address). An event on the read edge leaves the bit set. Reading one status register leaves the other unchanged.
- R4: Status one bit n follows `lim_a_i[n]`. Status two takes bits 0, 1, 6 and 7 from the same bits of `lim_b_i`. Bit 4 is set while `intr_i` is high, and bit 5 is set while `therm_ni` is low. Bits 2 and 3 stay 0, and `lim_b_i[5:2]` has no effect.
- R5: Writes to 0x41 and 0x42 are ignored.
- R6: `irq_no` is low exactly when a status bit is set and the mask bit in the same position is 0. It follows the registered status and masks with no extra delay.
- R7: Both mask registers and the scratch register store and return the whole written byte.
- R8: Writing 0x46 with bit 7 set while idle drives `intr_pulse_no` low from the next cycle for exactly PULSE_CYC cycles. Bit 7 of 0x46 reads 1 during the pulse and 0 after it.
- R9: A write of bit 7 of 0x46 during a pulse neither restarts nor extends that pulse.
- R10: While the pulse runs, `intr_i` does not set status two bit 4.
- R11: Bits 6:0 of 0x46 are plain read/write storage and do not start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears the addressed status register) |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| lim_a_i | input | 8 | Event flags for status one |
| lim_b_i | input | 8 | Event flags for status two (bits 0,1,6,7 used) |
| intr_i | input | 1 | Chassis-intrusion level, active high |
| therm_ni | input | 1 | Thermal alarm, active low |
| intr_pulse_no | output | 1 | Intrusion-clear pulse, active low |
| irq_no | output | 1 | Interrupt, active low |

## Verification
An event that is high across one rising edge is visible in the status register and on `irq_no` right after that edge. The bench drives events for exactly one cycle and checks the status and `irq_no` at the following falling edge. Register writes show on `reg_rdata_o` one edge after the strobe, and read data is combinational. For that reason each read samples shortly after the falling edge where it drives the address. The clear caused by a read happens at the next rising edge, and the bench checks it with a second read. The intrusion pulse starts one edge after the write. A counter clocked on falling edges measures its length and compares it with PULSE_CYC, and a retrigger write is placed mid-pulse.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 8;
  localparam int unsigned NUM_ST = 2;

  localparam logic [AW-1:0] A_ST1 = 8'h41;
  localparam logic [AW-1:0] A_MK1 = 8'h43;
  localparam logic [AW-1:0] A_RSV = 8'h45;
  localparam logic [AW-1:0] A_CLR = 8'h46;

  // bits that may ever be set, per status register
  localparam logic [NUM_ST-1:0][DW-1:0] ST_VALID = {8'hF3, 8'hFF};

  localparam int unsigned CLR_BIT  = DW - 1;
  localparam int unsigned INTR_BIT = 4;
  localparam int unsigned THRM_BIT = 5;
endpackage

// File: rtl/imc_status_reg.sv
module imc_status_reg #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;

  // read-clear wins over the held value, a live event wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= ((clr_i ? '0 : st_q) | evt_i) & VALID;
  end

  assign st_o = st_q;

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((st_q & $past(st_q)) == $past(st_q)));
  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> (st_q == '0));
  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & ~VALID) == '0);
endmodule

// File: rtl/imc_rw_reg.sv
module imc_rw_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= d_i;
  end

  assign q_o = q_q;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_q));
endmodule

// File: rtl/imc_intr_pulse.sv
module imc_intr_pulse #(
  parameter int unsigned PULSE_CYC = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic pulse_no
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);
  assign pulse_no = ~active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (start_i && !active_o) cnt_q <= CW'(PULSE_CYC);
    else if (active_o)             cnt_q <= cnt_q - 1'b1;
  end

  a_r8_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active_o) |=> !pulse_no);
  a_r9_no_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && active_o) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
  a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> pulse_no);
endmodule

// File: rtl/imc_top.sv
module imc_top
  import imc_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 5_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] lim_a_i,
  input  logic [DW-1:0] lim_b_i,
  input  logic          intr_i,
  input  logic          therm_ni,
  output logic          intr_pulse_no,
  output logic          irq_no
);
  logic [NUM_ST-1:0][DW-1:0] st, mk, evt;
  logic [DW-1:0]             rsv_q;
  logic [DW-2:0]             clr_lo_q;
  logic                      pulse_active;
  logic                      pulse_start;
  logic [3:0]                lim_b_unused;

  assign lim_b_unused = lim_b_i[5:2];

  always_comb begin
    evt[0]           = lim_a_i;
    evt[1]           = lim_b_i;
    evt[1][INTR_BIT] = intr_i & ~pulse_active; // own pulse must not flag
    evt[1][THRM_BIT] = ~therm_ni;
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_reg
    localparam logic [AW-1:0] ST_A = A_ST1 + AW'(g);
    localparam logic [AW-1:0] MK_A = A_MK1 + AW'(g);

    imc_status_reg #(.W(DW), .VALID(ST_VALID[g])) u_st (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[g]),
      .clr_i  (reg_re_i && (reg_addr_i == ST_A)),
      .st_o   (st[g])
    );

    imc_rw_reg #(.W(DW)) u_mk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i && (reg_addr_i == MK_A)),
      .d_i    (reg_wdata_i),
      .q_o    (mk[g])
    );
  end

  imc_rw_reg #(.W(DW)) u_rsv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i && (reg_addr_i == A_RSV)),
    .d_i    (reg_wdata_i),
    .q_o    (rsv_q)
  );

  imc_rw_reg #(.W(DW-1)) u_clr_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i && (reg_addr_i == A_CLR)),
    .d_i    (reg_wdata_i[DW-2:0]),
    .q_o    (clr_lo_q)
  );

  assign pulse_start = reg_we_i && (reg_addr_i == A_CLR) && reg_wdata_i[CLR_BIT];

  imc_intr_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (pulse_start),
    .active_o (pulse_active),
    .pulse_no (intr_pulse_no)
  );

  always_comb begin
    logic [DW-1:0] pend;
    pend = '0;
    for (int i = 0; i < NUM_ST; i++) pend |= st[i] & ~mk[i];
    irq_no = ~|pend;
  end

  always_comb begin
    case (reg_addr_i)
      A_ST1:        reg_rdata_o = st[0];
      A_ST1 + 8'd1: reg_rdata_o = st[1];
      A_MK1:        reg_rdata_o = mk[0];
      A_MK1 + 8'd1: reg_rdata_o = mk[1];
      A_RSV:        reg_rdata_o = rsv_q;
      A_CLR:        reg_rdata_o = {pulse_active, clr_lo_q};
      default:      reg_rdata_o = '0;
    endcase
  end

  a_r6_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk[0] == '1 && mk[1] == '1) |-> irq_no);
  a_r6_none_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st[0] == '0 && st[1] == '0) |-> irq_no);
  a_r10_no_self_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_active && !st[1][INTR_BIT]) |=> !st[1][INTR_BIT]);
  a_r8_bit_tracks_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CLR) |-> (reg_rdata_o[CLR_BIT] == !intr_pulse_no));
endmodule

// File: tb/sim_imc_top.sv
`timescale 1ns/1ps
module sim_imc_top;
  localparam int unsigned P = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [7:0] lim_a = '0, lim_b = '0;
  logic       intr = 1'b0, therm_n = 1'b1;
  logic       pulse_n, irq_n;
  int         n_run = 0, n_fail = 0, low_cnt = 0;
  logic [7:0] d;

  always #2 clk = ~clk;

  imc_top #(.PULSE_CYC(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .lim_a_i(lim_a), .lim_b_i(lim_b), .intr_i(intr), .therm_ni(therm_n),
    .intr_pulse_no(pulse_n), .irq_no(irq_n)
  );

  always @(negedge clk) if (!pulse_n) low_cnt++;

  // {lim_a, lim_b, intr, therm_n, mask1, mask2}
  localparam logic [33:0] VEC [7] = '{
    {8'h01, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'h80, 8'h00, 1'b0, 1'b1, 8'h80, 8'h00},
    {8'h00, 8'h3C, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00},
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h10},
    {8'h00, 8'hC3, 1'b0, 1'b1, 8'h00, 8'hC3},
    {8'hFF, 8'hFF, 1'b1, 1'b0, 8'hFF, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); we = 1'b1; addr = a; wdata = v;
    @(negedge clk); we = 1'b0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); re = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); re = 1'b0; addr = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 8'h41; a <= 8'h46; a++) begin
      rd(8'(a), d); chk("R1 reset reg", d, 8'h00);
    end
    chk("R1 irq_no", {7'd0, irq_n}, 8'h01);
    chk("R1 intr_pulse_no", {7'd0, pulse_n}, 8'h01);

    // vector table: R4 mapping, R6 masking
    foreach (VEC[i]) begin
      logic [7:0] ea, eb, m1, m2, s2;
      logic       ei, et;
      {ea, eb, ei, et, m1, m2} = VEC[i];
      rd(8'h41, d); rd(8'h42, d);
      wr(8'h43, m1); wr(8'h44, m2);
      @(negedge clk); lim_a = ea; lim_b = eb; intr = ei; therm_n = et;
      @(negedge clk); lim_a = '0; lim_b = '0; intr = 1'b0; therm_n = 1'b1;
      #1;
      s2 = {eb[7:6], ~et, ei, 2'b00, eb[1:0]};
      chk("R6 irq_no vector", {7'd0, irq_n}, {7'd0, ~|((ea & ~m1) | (s2 & ~m2))});
      rd(8'h41, d); chk("R4 status one vector", d, ea);
      rd(8'h42, d); chk("R4 status two vector", d, s2);
      #1 chk("R6 irq_no after clear", {7'd0, irq_n}, 8'h01);
    end
    wr(8'h43, 8'h00); wr(8'h44, 8'h00);

    // R7 storage
    wr(8'h43, 8'hA5); wr(8'h44, 8'h5A); wr(8'h45, 8'h3C);
    rd(8'h43, d); chk("R7 mask one", d, 8'hA5);
    rd(8'h44, d); chk("R7 mask two", d, 8'h5A);
    rd(8'h45, d); chk("R7 scratch", d, 8'h3C);

    // R2 unmapped
    wr(8'h50, 8'hFF); wr(8'h40, 8'hFF);
    rd(8'h50, d); chk("R2 unmapped 0x50", d, 8'h00);
    rd(8'h40, d); chk("R2 unmapped 0x40", d, 8'h00);
    rd(8'h45, d); chk("R2 scratch untouched", d, 8'h3C);
    rd(8'h43, d); chk("R2 mask untouched", d, 8'hA5);
    wr(8'h43, 8'h00); wr(8'h44, 8'h00);

    // R5 read-only status
    wr(8'h41, 8'hFF); wr(8'h42, 8'hFF);
    rd(8'h41, d); chk("R5 status one write", d, 8'h00);
    rd(8'h42, d); chk("R5 status two write", d, 8'h00);
    chk("R5 irq_no", {7'd0, irq_n}, 8'h01);

    // R3 sticky, read clear, same-cycle set, independence
    @(negedge clk); lim_a = 8'h02; lim_b = 8'h01;
    @(negedge clk); lim_a = '0; lim_b = '0;
    repeat (5) @(negedge clk);
    rd(8'h41, d); chk("R3 sticky", d, 8'h02);
    rd(8'h41, d); chk("R3 cleared by read", d, 8'h00);
    rd(8'h42, d); chk("R3 other register kept", d, 8'h01);
    @(negedge clk); lim_a = 8'h04; re = 1'b1; addr = 8'h41;
    #1 chk("R3 read during event", rdata, 8'h00);
    @(negedge clk); lim_a = '0; re = 1'b0; addr = 8'h00;
    rd(8'h41, d); chk("R3 event wins over clear", d, 8'h04);

    // R11 low bits storage, no pulse
    low_cnt = 0;
    wr(8'h46, 8'h15);
    rd(8'h46, d); chk("R11 low bits", d, 8'h15);
    repeat (3) @(negedge clk);
    chk("R11 no pulse", 8'(low_cnt), 8'h00);

    // R8 pulse, R9 retrigger, R10 self-flag
    low_cnt = 0;
    wr(8'h46, 8'h95);
    chk("R8 pulse started", {7'd0, pulse_n}, 8'h00);
    rd(8'h46, d); chk("R8 bit7 during pulse", d, 8'h95);
    repeat (8) @(negedge clk);
    wr(8'h46, 8'h95);
    intr = 1'b1;
    repeat (4) @(negedge clk);
    intr = 1'b0;
    repeat (P + 10) @(negedge clk);
    chk("R8 pulse width", 8'(low_cnt), 8'(P));
    chk("R9 not extended", {7'd0, pulse_n}, 8'h01);
    rd(8'h46, d); chk("R8 self clear", d, 8'h15);
    rd(8'h42, d); chk("R10 no self flag", d, 8'h00);

    // R4 intrusion flags again once the pulse is over
    @(negedge clk); intr = 1'b1;
    @(negedge clk); intr = 1'b0;
    rd(8'h42, d); chk("R4 intrusion after pulse", d, 8'h10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule